// File: doc/BRIEF.md
# Frame Aligner and Justification Demultiplexer

This block takes a high-speed NRZ bit stream, one bit per clock, that carries four bit-interleaved tributaries in a fixed-length frame. A single mode input selects the short frame (848 bits) or the long frame (1536 bits). The block looks for the 10-bit alignment word `1111010000`, confirms it at a fixed position, and raises a loss-of-frame flag whenever it is not locked. While locked, it extracts the alarm and national overhead bits and recovers each tributary as a data bit plus a one-cycle valid strobe. The strobes act as a gapped clock for a later desynchroniser.

Each frame is split into four equal sets. Set one opens with the alignment word, the alarm bit and the national bit. Sets two to four each open with one justification control bit per tributary. Set four then holds one justifiable slot per tributary. Every remaining position carries tributary data. At every position the tributary index is the 0-based position modulo 4. For each tributary, a 2-of-3 vote over its three control bits decides how its justifiable slot is used: as data, or as an auxiliary bit. An independent monitor flags a long run of ones on the input.

Top module: `tdm_frame_demux`

## Requirements
- R1: With mode low the frame is 848 bits of four 212-bit sets; with mode high it is 1536 bits of four 384-bit sets. A locked tributary gets 205 (low) or 377 (high) data strobes per frame, plus one more when its justifiable slot carries data.
- R2: `lof` is 1 from reset. It clears only after the alignment word has been seen at the same frame position in three consecutive frames. The clear happens at the clock edge that samples the last bit of the third word.
- R3: While locked, up to three consecutive frames with a wrong alignment word keep `lof` at 0. A correct word resets the miss count. The fourth consecutive miss sets `lof` to 1 and restarts the search.
- R4: The control bits sit at 0-based offsets 0..3 of sets two, three and four, one per tributary. The justifiable slots sit at offsets 4..7 of set four. If at least two of a tributary's three control bits are 1, its slot value goes to `aux_bit[t]` and no strobe is made. Otherwise the slot is delivered as data with a strobe.
- R5: `aux_bit[t]` changes only in frames in which tributary t's slot is voted as auxiliary. Otherwise it holds its value.
- R6: The bits at 0-based positions 10 and 11 are latched into `alarm_bit` and `national_bit` every locked frame.
- R7: While locked, `frame_sync` is 1 for exactly one cycle per frame: the cycle after the edge that samples the first bit of the alignment word.
- R8: `ais_det` rises after 768 consecutive 1s on `din` and stays high while the ones continue. It clears at the edge that samples the first 0.
- R9: No strobe is produced while `lof` is 1. At most one strobe is active per cycle. No strobe arises from the 12 overhead positions at the start of a frame, so each tributary misses exactly 3 strobes there.
- R10: A strobed `trib_data[t]` equals the input bit sampled at the previous edge, and the strobe appears one cycle after that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0: 848-bit frame, 1: 1536-bit frame |
| din | input | 1 | High-speed NRZ data, one bit per clock |
| lof | output | 1 | Loss of frame, high when not locked |
| frame_sync | output | 1 | One-cycle pulse for the first alignment bit |
| alarm_bit | output | 1 | Alarm overhead bit of the last locked frame |
| national_bit | output | 1 | National overhead bit of the last locked frame |
| ais_det | output | 1 | All-ones input detected |
| trib_data | output | 4 | Recovered data bit per tributary |
| trib_valid | output | 4 | Data strobe per tributary (gapped clock) |
| aux_bit | output | 4 | Auxiliary bit per tributary from stuffed slots |

## Verification
The hardest state to reach from the ports is the edge of the loss-of-frame hysteresis. To get there the stream must lock first. Then the alignment word must be corrupted in exactly three frames, one good frame must interrupt the run, and a run of four corrupt frames must follow before the fall of lock can be seen. The bench builds whole frames from a layout model of its own. It corrupts only the first alignment bit, so that no false word can appear elsewhere. It samples `lof` at frame boundaries to confirm that lock holds through three misses, drops on the fourth, and returns on the third good frame of the new search. It also pairs control-bit patterns with slot values so that every vote outcome shows up separately in the strobe counts and in the auxiliary outputs.

// File: rtl/tdm_demux_pkg.sv
package tdm_demux_pkg;

    localparam int unsigned NTRIB        = 4;
    localparam int unsigned TRIB_W       = $clog2(NTRIB);
    localparam int unsigned NSETS        = 4;
    localparam int unsigned NJ           = NSETS - 1;
    localparam int unsigned JIDX_W       = $clog2(NJ);
    localparam int unsigned SET_LEN_LO   = 212;
    localparam int unsigned SET_LEN_HI   = 384;
    localparam int unsigned FRAME_LEN_LO = SET_LEN_LO * NSETS;
    localparam int unsigned FRAME_LEN_HI = SET_LEN_HI * NSETS;
    localparam int unsigned POS_W        = $clog2(FRAME_LEN_HI);
    localparam int unsigned FAW_LEN      = 10;
    localparam logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000;
    localparam int unsigned ALM_OFS      = FAW_LEN;
    localparam int unsigned NAT_OFS      = FAW_LEN + 1;
    localparam int unsigned CONFIRMS     = 3;
    localparam int unsigned MISSES       = 4;

    typedef enum logic [1:0] {
        FR_SEEK,
        FR_CONFIRM,
        FR_LOCKED
    } frm_state_e;

    typedef enum logic [2:0] {
        SLOT_FAW,
        SLOT_ALM,
        SLOT_NAT,
        SLOT_JCTL,
        SLOT_STUFF,
        SLOT_DATA
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [TRIB_W-1:0]   trib;
        logic [JIDX_W-1:0]   jidx;
    } slot_t;

    function automatic int unsigned frame_len(input logic mode);
        return mode ? FRAME_LEN_HI : FRAME_LEN_LO;
    endfunction

    function automatic slot_t classify(input logic [POS_W-1:0] pos, input logic mode);
        slot_t       s;
        int unsigned sl;
        int unsigned p;
        int unsigned grp;
        int unsigned off;
        sl  = mode ? SET_LEN_HI : SET_LEN_LO;
        p   = 32'(pos);
        grp = 0;
        for (int unsigned g = 1; g < NSETS; g++) begin
            if (p >= g * sl) grp = g;
        end
        off    = p - grp * sl;
        s.trib = pos[TRIB_W-1:0];
        s.jidx = (grp == 0) ? '0 : JIDX_W'(grp - 1);
        if (grp == 0) begin
            if (off < FAW_LEN)       s.kind = SLOT_FAW;
            else if (off == ALM_OFS) s.kind = SLOT_ALM;
            else if (off == NAT_OFS) s.kind = SLOT_NAT;
            else                     s.kind = SLOT_DATA;
        end else if (off < NTRIB) begin
            s.kind = SLOT_JCTL;
        end else if (grp == NSETS - 1 && off < 2 * NTRIB) begin
            s.kind = SLOT_STUFF;
        end else begin
            s.kind = SLOT_DATA;
        end
        return s;
    endfunction

    function automatic logic vote3(input logic [NJ-1:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/frame_seeker.sv
module frame_seeker
    import tdm_demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             din,
    output logic [POS_W-1:0] pos,
    output logic             lof,
    output logic             frame_sync
);
    localparam int unsigned HIT_W  = $clog2(CONFIRMS + 1);
    localparam int unsigned MISS_W = $clog2(MISSES + 1);

    frm_state_e          state;
    logic [FAW_LEN-2:0]  hist;
    logic [FAW_LEN-1:0]  window;
    logic                hit;
    logic                at_check;
    logic                at_end;
    logic [HIT_W-1:0]    hits;
    logic [MISS_W-1:0]   misses;

    assign window   = {hist, din};
    assign hit      = (window == FAW_WORD);
    assign at_check = (pos == POS_W'(FAW_LEN - 1));
    assign at_end   = (32'(pos) == frame_len(mode) - 1);
    assign lof      = (state != FR_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FR_SEEK;
            hist       <= '0;
            pos        <= '0;
            hits       <= '0;
            misses     <= '0;
            frame_sync <= 1'b0;
        end else begin
            hist       <= window[FAW_LEN-2:0];
            frame_sync <= (state == FR_LOCKED) && (pos == '0);
            if (state == FR_SEEK && hit)  pos <= POS_W'(FAW_LEN);
            else if (at_end)              pos <= '0;
            else                          pos <= pos + 1'b1;
            unique case (state)
                FR_SEEK: begin
                    if (hit) begin
                        state <= FR_CONFIRM;
                        hits  <= HIT_W'(1);
                    end
                end
                FR_CONFIRM: begin
                    if (at_check) begin
                        if (!hit) begin
                            state <= FR_SEEK;
                        end else if (hits == HIT_W'(CONFIRMS - 1)) begin
                            state  <= FR_LOCKED;
                            misses <= '0;
                        end else begin
                            hits <= hits + 1'b1;
                        end
                    end
                end
                FR_LOCKED: begin
                    if (at_check) begin
                        if (hit) begin
                            misses <= '0;
                        end else if (misses == MISS_W'(MISSES - 1)) begin
                            state <= FR_SEEK;
                        end else begin
                            misses <= misses + 1'b1;
                        end
                    end
                end
                default: state <= FR_SEEK;
            endcase
        end
    end

    // R2
    lof_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lof) |-> ($past(pos) == POS_W'(FAW_LEN - 1)));

    // R3
    lof_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lof) |-> (($past(pos) == POS_W'(FAW_LEN - 1)) || $past(rst)));

    // R7
    frame_sync_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> (!lof && pos == POS_W'(1)));

endmodule

// File: rtl/ais_monitor.sv
module ais_monitor #(
    parameter int unsigned AIS_RUN = 768
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic ais_det
);
    localparam int unsigned CW = $clog2(AIS_RUN + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= '0;
            ais_det <= 1'b0;
        end else if (!din) begin
            run     <= '0;
            ais_det <= 1'b0;
        end else if (run < CW'(AIS_RUN)) begin
            run     <= run + 1'b1;
            ais_det <= ((run + 1'b1) == CW'(AIS_RUN));
        end
    end

    // R8
    ais_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(din) && !$past(rst)) |-> !ais_det);

    // R8
    ais_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_det) |-> $past(din));

endmodule

// File: rtl/trib_extractor.sv
module trib_extractor
    import tdm_demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             din,
    input  logic [POS_W-1:0] pos,
    input  logic             in_lock,
    output logic [NTRIB-1:0] trib_data,
    output logic [NTRIB-1:0] trib_valid,
    output logic [NTRIB-1:0] aux_bit,
    output logic             alarm_bit,
    output logic             national_bit
);
    slot_t slot;
    assign slot = classify(pos, mode);

    for (genvar t = 0; t < NTRIB; t++) begin : g_lane
        logic [NJ-1:0] jst;
        logic          lane_data;
        logic          lane_valid;
        logic          lane_aux;
        logic          mine;

        assign mine = in_lock && (slot.trib == TRIB_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                jst        <= '0;
                lane_data  <= 1'b0;
                lane_valid <= 1'b0;
                lane_aux   <= 1'b0;
            end else begin
                lane_valid <= 1'b0;
                if (mine) begin
                    case (slot.kind)
                        SLOT_JCTL: jst[slot.jidx] <= din;
                        SLOT_STUFF: begin
                            if (vote3(jst)) begin
                                lane_aux <= din;
                            end else begin
                                lane_data  <= din;
                                lane_valid <= 1'b1;
                            end
                        end
                        SLOT_DATA: begin
                            lane_data  <= din;
                            lane_valid <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end

        assign trib_data[t]  = lane_data;
        assign trib_valid[t] = lane_valid;
        assign aux_bit[t]    = lane_aux;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_bit    <= 1'b0;
            national_bit <= 1'b0;
        end else if (in_lock) begin
            if (slot.kind == SLOT_ALM) alarm_bit    <= din;
            if (slot.kind == SLOT_NAT) national_bit <= din;
        end
    end

    // R9
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trib_valid));

    // R9
    strobe_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (|trib_valid) |-> $past(in_lock));

    // R5
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_lock) |-> $stable(aux_bit));

    // R10
    data_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|trib_valid) |-> ((trib_data & trib_valid) == ({NTRIB{$past(din)}} & trib_valid)));

endmodule

// File: rtl/tdm_frame_demux.sv
module tdm_frame_demux
    import tdm_demux_pkg::*;
#(
    parameter int unsigned AIS_RUN = 768
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             din,
    output logic             lof,
    output logic             frame_sync,
    output logic             alarm_bit,
    output logic             national_bit,
    output logic             ais_det,
    output logic [NTRIB-1:0] trib_data,
    output logic [NTRIB-1:0] trib_valid,
    output logic [NTRIB-1:0] aux_bit
);
    logic [POS_W-1:0] pos;

    frame_seeker u_seek (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .din        (din),
        .pos        (pos),
        .lof        (lof),
        .frame_sync (frame_sync)
    );

    trib_extractor u_extr (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .din          (din),
        .pos          (pos),
        .in_lock      (!lof),
        .trib_data    (trib_data),
        .trib_valid   (trib_valid),
        .aux_bit      (aux_bit),
        .alarm_bit    (alarm_bit),
        .national_bit (national_bit)
    );

    ais_monitor #(.AIS_RUN(AIS_RUN)) u_ais (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .ais_det (ais_det)
    );

endmodule

// File: tb/tdm_frame_demux_test.sv
module tdm_frame_demux_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       din = 1'b0;
    logic       lof, frame_sync, alarm_bit, national_bit, ais_det;
    logic [3:0] trib_data, trib_valid, aux_bit;

    always #5 clk = ~clk;

    tdm_frame_demux uut (
        .clk(clk), .rst(rst), .mode(mode), .din(din),
        .lof(lof), .frame_sync(frame_sync), .alarm_bit(alarm_bit),
        .national_bit(national_bit), .ais_det(ais_det),
        .trib_data(trib_data), .trib_valid(trib_valid), .aux_bit(aux_bit)
    );

    // vector: {mode, jctl[11:0] (3 bits per tributary, bit k = control bit of set k+2),
    //          slot[3:0], alarm, national, expected stuffed mask[3:0]}
    localparam logic [22:0] VECS [5] = '{
        {1'b0, 12'b100_011_111_000, 4'b1011, 1'b1, 1'b0, 4'b0110},
        {1'b0, 12'b010_110_001_101, 4'b0100, 1'b0, 1'b1, 4'b0101},
        {1'b0, 12'b000_000_000_000, 4'b1111, 1'b1, 1'b1, 4'b0000},
        {1'b1, 12'b011_101_000_111, 4'b0101, 1'b0, 1'b0, 4'b1101},
        {1'b1, 12'b111_100_110_001, 4'b1010, 1'b1, 1'b0, 4'b1010}
    };
    localparam logic [9:0] ALIGN = 10'b1111010000;

    int n_chk = 0;
    int n_bad = 0;
    int cur_pos;
    int cnt [4];
    int ones [4];
    int exp_ones [4];
    int sync_cnt, sync_at0, early, gate_err;
    logic [3:0] exp_aux;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int kind_of(input int p, input bit m);
        int sl = m ? 384 : 212;
        int g  = p / sl;
        int o  = p % sl;
        if (g == 0) return (o < 10) ? 0 : (o == 10) ? 1 : (o == 11) ? 2 : 5;
        if (o < 4) return 3;
        if (g == 3 && o < 8) return 4;
        return 5;
    endfunction

    function automatic logic gen_bit(input int p, input bit m, input logic [22:0] v, input bit bad);
        int sl = m ? 384 : 212;
        int t  = p % 4;
        case (kind_of(p, m))
            0: return ALIGN[9-p] ^ (bad && p == 0);
            1: return v[5];
            2: return v[4];
            3: return v[10 + 3*t + (p/sl - 1)];
            4: return v[6 + t];
            default: return (p % 3 == 0);
        endcase
    endfunction

    task automatic step(input logic b);
        din = b;
        @(posedge clk);
        #1;
        for (int t = 0; t < 4; t++) begin
            if (trib_valid[t]) begin
                cnt[t]++;
                ones[t] += int'(trib_data[t]);
            end
        end
        if (frame_sync) begin
            sync_cnt++;
            if (cur_pos == 0) sync_at0++;
        end
        if (cur_pos < 12 && |trib_valid) early++;
        if (lof && |trib_valid) gate_err++;
    endtask

    task automatic send_frame(input logic [22:0] v, input bit bad);
        int len = v[22] ? 1536 : 848;
        for (int t = 0; t < 4; t++) begin cnt[t] = 0; ones[t] = 0; exp_ones[t] = 0; end
        sync_cnt = 0; sync_at0 = 0; early = 0;
        for (int p = 0; p < len; p++) begin
            logic b;
            b = gen_bit(p, v[22], v, bad);
            if (kind_of(p, v[22]) == 5) exp_ones[p % 4] += int'(b);
            cur_pos = p;
            step(b);
        end
    endtask

    task automatic do_reset(input bit m);
        mode = m; rst = 1'b1; din = 1'b0; cur_pos = 9999; gate_err = 0;
        exp_aux = 4'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic measure(input logic [22:0] v, input int idx);
        int base = v[22] ? 377 : 205;
        send_frame(v, 1'b0);
        for (int t = 0; t < 4; t++) begin
            if (v[t]) exp_aux[t] = v[6 + t];
            // R1 R4 strobe count per tributary
            chk($sformatf("R1/R4 vec%0d trib%0d strobes", idx, t), cnt[t], base + (v[t] ? 0 : 1));
            // R10 delivered data content
            chk($sformatf("R10 vec%0d trib%0d ones", idx, t), ones[t],
                exp_ones[t] + ((v[t] == 1'b0) ? int'(v[6 + t]) : 0));
        end
        // R5 auxiliary outputs
        chk($sformatf("R5 vec%0d aux", idx), int'(aux_bit), int'(exp_aux));
        // R6 overhead bits
        chk($sformatf("R6 vec%0d alarm", idx), int'(alarm_bit), int'(v[5]));
        chk($sformatf("R6 vec%0d national", idx), int'(national_bit), int'(v[4]));
        // R7 one sync pulse, on the first alignment bit
        chk($sformatf("R7 vec%0d sync count", idx), sync_cnt, 1);
        chk($sformatf("R7 vec%0d sync position", idx), sync_at0, 1);
        // R9 overhead gap
        chk($sformatf("R9 vec%0d overhead strobes", idx), early, 0);
        chk($sformatf("R2 vec%0d locked", idx), int'(lof), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // reset state
        do_reset(1'b0);
        chk("R2 reset lof", int'(lof), 1);
        chk("R9 reset strobes", int'(trib_valid), 0);
        chk("R8 reset ais", int'(ais_det), 0);
        chk("R7 reset sync", int'(frame_sync), 0);
        chk("R5 reset aux", int'(aux_bit), 0);

        // R8 all-ones run
        repeat (767) step(1'b1);
        chk("R8 after 767 ones", int'(ais_det), 0);
        step(1'b1);
        chk("R8 after 768 ones", int'(ais_det), 1);
        repeat (5) step(1'b1);
        chk("R8 held while ones continue", int'(ais_det), 1);
        step(1'b0);
        chk("R8 cleared by zero", int'(ais_det), 0);

        // table of vectors
        for (int i = 0; i < 5; i++) begin
            if (i == 0 || VECS[i][22] != VECS[i-1][22]) begin
                do_reset(VECS[i][22]);
                for (int f = 0; f < 12; f++) begin
                    send_frame(VECS[i], 1'b0);
                    if (!lof) break;
                end
                chk($sformatf("R2 sync vec%0d", i), int'(lof), 0);
                chk($sformatf("R9 no strobes while unlocked vec%0d", i), gate_err, 0);
            end
            for (int r = 0; r < 2; r++) measure(VECS[i], i);
        end

        // R2 exact lock timing and R3 hysteresis
        do_reset(1'b0);
        send_frame(VECS[2], 1'b0);
        send_frame(VECS[2], 1'b0);
        chk("R2 lof after two words", int'(lof), 1);
        send_frame(VECS[2], 1'b0);
        chk("R2 lof after third word", int'(lof), 0);
        repeat (3) send_frame(VECS[2], 1'b1);
        chk("R3 three misses keep lock", int'(lof), 0);
        send_frame(VECS[2], 1'b0);
        repeat (3) send_frame(VECS[2], 1'b1);
        chk("R3 miss count restarted by good word", int'(lof), 0);
        send_frame(VECS[2], 1'b1);
        chk("R3 fourth miss drops lock", int'(lof), 1);
        gate_err = 0;
        send_frame(VECS[2], 1'b0);
        send_frame(VECS[2], 1'b0);
        chk("R2 relock pending after two words", int'(lof), 1);
        chk("R9 no strobes during search", gate_err, 0);
        send_frame(VECS[2], 1'b0);
        chk("R2 relocked after third word", int'(lof), 0);
        measure(VECS[2], 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule